// File: doc/BRIEF.md
# Dual-Counter PWM Timer

This block holds two identical reloadable timers and combines them into one pulse-width-modulated output. Timer 0 sets the period and timer 1 sets the high time. Each timer has a control word, a load register and a counter. Software reaches all three through a small word-addressed register port. A timer counts up or down. It can take a forced load from its load register, reload itself automatically at terminal count, and emit a one-clock pulse after every terminal count.

To run the PWM, software writes both load registers and copies them into the counters with the load bit. It then writes timer 0's control word without its enable bit and timer 1's control word with the enable-all bit set. Both timers start on the same clock. From then on, the output rises one clock after each period terminal count and falls one clock after the duty timer's terminal count. While PWM mode is valid, the duty timer is reloaded together with the period timer, so every period starts aligned. Any loss of the joint configuration forces the output low.

Top module: `dual_timer_pwm`

## Requirements
- R1: After reset, every register reads zero, and pwmOut and genOut are low.
- R2: The word addresses are 0 = control 0, 1 = load 0, 2 = counter 0, 3 = control 1, 4 = load 1, 5 = counter 1. Read data appears on regRdata one clock after regRe. Writes to the counter addresses are ignored. Control bits are: 0 enable, 1 count down, 2 auto-reload, 3 load, 4 generate-out enable, 5 PWM enable, 6 capture mode (0 = generate), 7 enable-all, 8 cascade.
- R3: While the load bit is set, the counter takes the load register value on every clock.
- R4: Counting up with width W, load value L gives a cycle of (2^W - 1) - L + 2 clocks, seen as the spacing of genOut pulses.
- R5: Counting down, load value L gives a cycle of L + 2 clocks.
- R6: With auto-reload, a load value written while the timer runs is used only from the next reload. The cycle in progress keeps its old length.
- R7: Without auto-reload, the counter stops at terminal count (all ones up, zero down) and the timer's enable bit clears.
- R8: genOut[i] pulses for one clock after each terminal count of timer i, only in generate mode with generate-out enabled.
- R9: A control write with the enable-all bit (at address 0 or 3) sets both enable bits on the same clock, whatever enable value was written. The enable-all bit reads back as zero.
- R10: In valid PWM mode with period P and duty D < P cycles, pwmOut has period P and stays high for exactly D clocks, in both count directions.
- R11: When the duty cycle length equals the period length, pwmOut stays low.
- R12: PWM mode is valid only if both timers are enabled, in generate mode, with PWM, generate-out and auto-reload set, the load bit clear, and cascade clear on timer 0. Otherwise pwmOut is low from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 3 | Word address |
| regWdata | input | DATA_W | Write data (DATA_W = max(CNT_W, 9)) |
| regRdata | output | DATA_W | Read data, valid one clock after regRe |
| genOut | output | 2 | Per-timer terminal-count pulse |
| pwmOut | output | 1 | PWM output |

## Verification
A wrong reload flag or counter value shows up at genOut as a pulse spacing that is off by one or more clocks. This is visible within one timer cycle, at most 2^W + 1 clocks. A duty timer that fails to realign with the period timer shifts or stretches the pwmOut high time in the next period. A stray enable or load bit shows within a clock, either as a counter read-back that differs from the computed value or as pwmOut failing to drop.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;
  localparam int CTRL_W   = 9;
  localparam int B_EN     = 0;
  localparam int B_DOWN   = 1;
  localparam int B_RELOAD = 2;
  localparam int B_LOAD   = 3;
  localparam int B_GENOUT = 4;
  localparam int B_PWM    = 5;
  localparam int B_CAPT   = 6;
  localparam int B_ENALL  = 7;
  localparam int B_CASC   = 8;
  localparam int N_TMR    = 2;
  localparam int WORDS_PER_TMR = 3;

  // Strobes from the register control to one timer datapath
  typedef struct packed {
    logic run;
    logic down;
    logic autoReload;
    logic holdLoad;
    logic genOutEn;
    logic captMode;
  } tmrStrobe_t;

  function automatic logic [2:0] addrOf(input int tmr, input int word);
    return 3'(tmr * WORDS_PER_TMR + word);
  endfunction
endpackage

// File: rtl/dtpwm_regs.sv
module dtpwm_regs
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DATA_W = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWe,
  input  logic regRe,
  input  logic [2:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [N_TMR-1:0][CNT_W-1:0] cntVal,
  input  logic [N_TMR-1:0] stopEvt,
  output logic [N_TMR-1:0][CTRL_W-1:0] ctrlWord,
  output logic [N_TMR-1:0][CNT_W-1:0] loadVal,
  output tmrStrobe_t [N_TMR-1:0] strobes,
  output logic [N_TMR-1:0] pwmEnB,
  output logic casc0
);
  logic [N_TMR-1:0][CTRL_W-1:0] ctrlNext;
  logic [N_TMR-1:0][CNT_W-1:0] loadNext;
  logic [DATA_W-1:0] rdNext;
  logic enAllHit;

  assign enAllHit = regWe && regWdata[B_ENALL] &&
                    (regAddr == addrOf(0, 0) || regAddr == addrOf(1, 0));

  always_comb begin
    ctrlNext = ctrlWord;
    loadNext = loadVal;
    for (int i = 0; i < N_TMR; i++) begin
      if (stopEvt[i]) ctrlNext[i][B_EN] = 1'b0;
      if (regWe && regAddr == addrOf(i, 0)) begin
        ctrlNext[i] = regWdata[CTRL_W-1:0];
        ctrlNext[i][B_ENALL] = 1'b0;
      end
      if (regWe && regAddr == addrOf(i, 1)) loadNext[i] = regWdata[CNT_W-1:0];
    end
    if (enAllHit) begin
      for (int i = 0; i < N_TMR; i++) ctrlNext[i][B_EN] = 1'b1;
    end
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (regAddr == addrOf(i, 0)) rdNext[CTRL_W-1:0] = ctrlWord[i];
      if (regAddr == addrOf(i, 1)) rdNext[CNT_W-1:0] = loadVal[i];
      if (regAddr == addrOf(i, 2)) rdNext[CNT_W-1:0] = cntVal[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
      loadVal  <= '0;
      regRdata <= '0;
    end else begin
      ctrlWord <= ctrlNext;
      loadVal  <= loadNext;
      if (regRe) regRdata <= rdNext;
    end
  end

  generate
    for (genvar i = 0; i < N_TMR; i++) begin : g_strb
      assign strobes[i].run        = ctrlWord[i][B_EN];
      assign strobes[i].down       = ctrlWord[i][B_DOWN];
      assign strobes[i].autoReload = ctrlWord[i][B_RELOAD];
      assign strobes[i].holdLoad   = ctrlWord[i][B_LOAD];
      assign strobes[i].genOutEn   = ctrlWord[i][B_GENOUT];
      assign strobes[i].captMode   = ctrlWord[i][B_CAPT];
      assign pwmEnB[i]             = ctrlWord[i][B_PWM];
    end
  endgenerate
  assign casc0 = ctrlWord[0][B_CASC];
endmodule

// File: rtl/dtpwm_timer.sv
module dtpwm_timer
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  tmrStrobe_t cfg,
  input  logic [CNT_W-1:0] loadVal,
  input  logic slaveMode,
  input  logic forceReload,
  output logic [CNT_W-1:0] cnt,
  output logic atTc,
  output logic stopEvt,
  output logic reloadEvt,
  output logic genPulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic pending;
  logic active;

  assign active    = cfg.run && !cfg.holdLoad;
  assign atTc      = active && !pending && (cfg.down ? (cnt == '0) : (cnt == CNT_MAX));
  assign reloadEvt = active && pending && !slaveMode;
  assign stopEvt   = atTc && !cfg.autoReload;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      pending  <= 1'b0;
      genPulse <= 1'b0;
    end else begin
      genPulse <= atTc && cfg.genOutEn && !cfg.captMode;
      if (cfg.holdLoad || forceReload) begin
        cnt     <= loadVal;
        pending <= 1'b0;
      end else if (cfg.run) begin
        if (pending) begin
          if (!slaveMode) begin
            cnt     <= loadVal;
            pending <= 1'b0;
          end
        end else if (!stopEvt) begin
          cnt <= cfg.down ? cnt - 1'b1 : cnt + 1'b1;
          if (atTc) pending <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dtpwm_core.sv
module dtpwm_core
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  tmrStrobe_t [N_TMR-1:0] strobes,
  input  logic [N_TMR-1:0] pwmEnB,
  input  logic casc0,
  input  logic [N_TMR-1:0][CNT_W-1:0] loadVal,
  output logic [N_TMR-1:0][CNT_W-1:0] cntVal,
  output logic [N_TMR-1:0] tcEvt,
  output logic [N_TMR-1:0] stopEvt,
  output logic [N_TMR-1:0] genOut,
  output logic pwmOut
);
  logic [N_TMR-1:0] tmrOk;
  logic [N_TMR-1:0] reloadEvt;
  logic [N_TMR-1:0] slaveVec;
  logic [N_TMR-1:0] forceVec;
  logic pwmValid;

  generate
    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
      assign tmrOk[i] = strobes[i].run && !strobes[i].captMode && pwmEnB[i] &&
                        strobes[i].genOutEn && strobes[i].autoReload &&
                        !strobes[i].holdLoad;
      dtpwm_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk),
        .rstN(rstN),
        .cfg(strobes[i]),
        .loadVal(loadVal[i]),
        .slaveMode(slaveVec[i]),
        .forceReload(forceVec[i]),
        .cnt(cntVal[i]),
        .atTc(tcEvt[i]),
        .stopEvt(stopEvt[i]),
        .reloadEvt(reloadEvt[i]),
        .genPulse(genOut[i])
      );
    end
  endgenerate

  assign pwmValid = &tmrOk && !casc0;
  // duty timer follows the period timer's reload while PWM is valid
  assign slaveVec = {pwmValid, 1'b0};
  assign forceVec = {pwmValid && reloadEvt[0], pwmValid && reloadEvt[1]};

  always_ff @(posedge clk) begin
    if (!rstN) pwmOut <= 1'b0;
    else       pwmOut <= pwmValid && (pwmOut || tcEvt[0]) && !tcEvt[1];
  end
endmodule

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int DATA_W = (CNT_W > CTRL_W) ? CNT_W : CTRL_W
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWe,
  input  logic regRe,
  input  logic [2:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [1:0] genOut,
  output logic pwmOut
);
  logic [N_TMR-1:0][CTRL_W-1:0] ctrlWord;
  logic [N_TMR-1:0][CNT_W-1:0] loadVal;
  logic [N_TMR-1:0][CNT_W-1:0] cntVal;
  logic [N_TMR-1:0] tcEvt;
  logic [N_TMR-1:0] stopEvt;
  logic [N_TMR-1:0] pwmEnB;
  logic casc0;
  tmrStrobe_t [N_TMR-1:0] strobes;

  dtpwm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cntVal(cntVal), .stopEvt(stopEvt),
    .ctrlWord(ctrlWord), .loadVal(loadVal), .strobes(strobes), .pwmEnB(pwmEnB),
    .casc0(casc0)
  );

  dtpwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pwmEnB(pwmEnB), .casc0(casc0),
    .loadVal(loadVal), .cntVal(cntVal), .tcEvt(tcEvt), .stopEvt(stopEvt),
    .genOut(genOut), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/dual_timer_pwm_checker.sv
module dual_timer_pwm_checker #(
  parameter int CNT_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic regWe,
  input logic [2:0] regAddr,
  input logic enAllBit,
  input logic pwmOut,
  input logic [1:0] genOut,
  input logic [1:0] tcEvt,
  input logic [1:0] runB,
  input logic [1:0] captB,
  input logic [1:0] pwmB,
  input logic [1:0] genB,
  input logic [1:0] relB,
  input logic [1:0] ldB,
  input logic casc0,
  input logic [1:0][CNT_W-1:0] loadVal,
  input logic [1:0][CNT_W-1:0] cntVal
);
  logic validNow;
  assign validNow = &(runB & ~captB & pwmB & genB & relB & ~ldB) && !casc0;

  // R12: invalid joint configuration drives the output low next clock
  a_r12_low_when_invalid: assert property (@(posedge clk) disable iff (!rstN)
    !validNow |=> !pwmOut);

  // R10: a rising output edge follows a period terminal count
  a_r10_rise_after_tc0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> $past(tcEvt[0]));

  // R9: enable-all sets both enable bits
  a_r9_enall_both: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && enAllBit && (regAddr == 3'd0 || regAddr == 3'd3)) |=> (runB == 2'b11));

  generate
    for (genvar i = 0; i < 2; i++) begin : g_chk
      // R3: held load bit copies the load register into the counter
      a_r3_load_copies: assert property (@(posedge clk) disable iff (!rstN)
        ldB[i] |=> (cntVal[i] == $past(loadVal[i])));
      // R8: a generate pulse always follows a terminal count
      a_r8_genout_after_tc: assert property (@(posedge clk) disable iff (!rstN)
        genOut[i] |-> $past(tcEvt[i]));
    end
  endgenerate
endmodule

bind dual_timer_pwm dual_timer_pwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .regWe(regWe),
  .regAddr(regAddr),
  .enAllBit(regWdata[dtpwm_pkg::B_ENALL]),
  .pwmOut(pwmOut),
  .genOut(genOut),
  .tcEvt(tcEvt),
  .runB({ctrlWord[1][dtpwm_pkg::B_EN], ctrlWord[0][dtpwm_pkg::B_EN]}),
  .captB({ctrlWord[1][dtpwm_pkg::B_CAPT], ctrlWord[0][dtpwm_pkg::B_CAPT]}),
  .pwmB({ctrlWord[1][dtpwm_pkg::B_PWM], ctrlWord[0][dtpwm_pkg::B_PWM]}),
  .genB({ctrlWord[1][dtpwm_pkg::B_GENOUT], ctrlWord[0][dtpwm_pkg::B_GENOUT]}),
  .relB({ctrlWord[1][dtpwm_pkg::B_RELOAD], ctrlWord[0][dtpwm_pkg::B_RELOAD]}),
  .ldB({ctrlWord[1][dtpwm_pkg::B_LOAD], ctrlWord[0][dtpwm_pkg::B_LOAD]}),
  .casc0(ctrlWord[0][dtpwm_pkg::B_CASC]),
  .loadVal(loadVal),
  .cntVal(cntVal)
);

// File: tb/dual_timer_pwm_bench.sv
`timescale 1ns/1ps
module dual_timer_pwm_bench;
  localparam int W = 8;
  localparam int DW = 9;
  localparam int MAXV = (1 << W) - 1;
  localparam int EN = 1, DN = 2, RL = 4, LD = 8, GO = 16, PW = 32, CP = 64, EA = 128, CS = 256;
  localparam int PSET = EN | RL | GO | PW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic regRe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic [1:0] genOut;
  logic pwmOut;
  int cyc = 0;
  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_timer_pwm #(.CNT_W(W)) u_dual_timer_pwm (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .genOut(genOut), .pwmOut(pwmOut)
  );

  function automatic int upLen(input int l);   return MAXV - l + 2; endfunction
  function automatic int downLen(input int l); return l + 2; endfunction
  function automatic int upLoad(input int n);  return MAXV + 2 - n; endfunction
  function automatic int downLoad(input int n); return n - 2; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'(a); regWdata = DW'(d);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    regRe = 1'b1; regAddr = 3'(a);
    @(negedge clk);
    regRe = 1'b0;
    d = int'(regRdata);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic waitPulse(input int idx, output int t);
    int guard = 0;
    @(negedge clk);
    while (!genOut[idx] && guard < 2000) begin @(negedge clk); guard++; end
    t = cyc;
    if (guard >= 2000) check(1'b0, "R8 pulse timeout", 0, 1);
  endtask

  task automatic waitPwm(input bit lvl, output int t);
    int guard = 0;
    @(negedge clk);
    while (pwmOut !== lvl && guard < 2000) begin @(negedge clk); guard++; end
    t = cyc;
    if (guard >= 2000) check(1'b0, "R10 pwm timeout", 0, 1);
  endtask

  task automatic stopAll();
    wr(0, 0); wr(3, 0);
  endtask

  task automatic soloStart(input int ld, input int ctl);
    stopAll();
    wr(1, ld); wr(0, LD); wr(0, ctl);
  endtask

  task automatic pwmStart(input int p, input int d, input bit down);
    int dn = down ? DN : 0;
    stopAll();
    wr(1, down ? downLoad(p) : upLoad(p));
    wr(4, down ? downLoad(d) : upLoad(d));
    wr(0, LD); wr(3, LD);
    wr(0, (PSET & ~EN) | dn);
    wr(3, PSET | EA | dn);
  endtask

  task automatic pwmMeasure(input int p, input int d, input string tag);
    int r1, f1, r2;
    waitPwm(1'b0, r1);
    waitPwm(1'b1, r1);
    waitPwm(1'b0, f1);
    waitPwm(1'b1, r2);
    check((f1 - r1) == d, {tag, " R10 high time"}, f1 - r1, d);
    check((r2 - r1) == p, {tag, " R10 period"}, r2 - r1, p);
  endtask

  task automatic stayLow(input int n, input string req);
    bit seen = 1'b0;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (pwmOut) seen = 1'b1; end
    check(!seen, req, int'(seen), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFail++; nChk++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    int v, t1, t2, t3, ld, p, d;
    void'($urandom(32'h1d2c3b4a));
    idle(3);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    check(pwmOut == 1'b0 && genOut == 2'b00, "R1 outputs", int'({genOut, pwmOut}), 0);
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      check(v == 0, "R1 register reset", v, 0);
    end

    // R2: counter address is read-only; R3: load bit copies
    wr(2, 9'h55);
    rd(2, v);
    check(v == 0, "R2 counter write ignored", v, 0);
    wr(4, 77); wr(3, LD);
    rd(5, v);
    check(v == 77, "R3 load copies counter 1", v, 77);
    wr(4, 12); idle(2);
    rd(5, v);
    check(v == 12, "R3 counter follows load while held", v, 12);
    rd(4, v);
    check(v == 12, "R2 load register read", v, 12);

    // R4: up-count lengths
    for (int n = 0; n < 3; n++) begin
      ld = (n == 0) ? MAXV : int'($urandom_range(0, MAXV - 1));
      soloStart(ld, EN | RL | GO);
      waitPulse(0, t1); waitPulse(0, t2);
      check((t2 - t1) == upLen(ld), "R4 up cycle length", t2 - t1, upLen(ld));
    end

    // R5: down-count lengths (includes load 0, the shortest)
    for (int n = 0; n < 3; n++) begin
      ld = (n == 0) ? 0 : int'($urandom_range(1, MAXV));
      soloStart(ld, EN | DN | RL | GO);
      waitPulse(0, t1); waitPulse(0, t2);
      check((t2 - t1) == downLen(ld), "R5 down cycle length", t2 - t1, downLen(ld));
    end

    // R6: new load value takes effect only at the next reload
    stopAll();
    wr(4, 200); wr(3, LD); wr(3, EN | RL | GO);
    waitPulse(1, t1);
    wr(4, 150);
    waitPulse(1, t2); waitPulse(1, t3);
    check((t2 - t1) == upLen(200), "R6 old length kept", t2 - t1, upLen(200));
    check((t3 - t2) == upLen(150), "R6 new length after reload", t3 - t2, upLen(150));

    // R7: one-shot stops at terminal count and clears enable
    soloStart(200, EN);
    idle(100);
    rd(2, v);
    check(v == MAXV, "R7 up counter holds at max", v, MAXV);
    rd(0, v);
    check((v & EN) == 0, "R7 enable cleared", v & EN, 0);
    soloStart(30, EN | DN);
    idle(60);
    rd(2, v);
    check(v == 0, "R7 down counter holds at zero", v, 0);

    // R8: no pulse without generate-out enable or in capture mode
    soloStart(250, EN | RL);
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 30; k++) begin @(negedge clk); if (genOut[0]) seen = 1'b1; end
      check(!seen, "R8 no pulse when generate-out off", int'(seen), 0);
    end
    soloStart(250, EN | RL | GO | CP);
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 30; k++) begin @(negedge clk); if (genOut[0]) seen = 1'b1; end
      check(!seen, "R8 no pulse in capture mode", int'(seen), 0);
    end

    // R9 + R10: joint start with enable-all, random pairs both directions
    for (int n = 0; n < 4; n++) begin
      p = int'($urandom_range(5, 120));
      d = int'($urandom_range(2, p - 1));
      pwmStart(p, d, n[0]);
      if (n == 0) begin
        rd(0, v);
        check((v & EN) == EN, "R9 timer 0 enabled by enable-all", v & EN, EN);
        rd(3, v);
        check((v & EA) == 0, "R9 enable-all reads zero", v & EA, 0);
      end
      pwmMeasure(p, d, n[0] ? "down" : "up");
    end
    pwmStart(40, 39, 1'b0);
    pwmMeasure(40, 39, "edge");
    pwmStart(40, 2, 1'b1);
    pwmMeasure(40, 2, "edge");

    // R11: duty equals period gives constant low
    pwmStart(30, 30, 1'b0);
    stayLow(120, "R11 equal lengths stay low");

    // R12: invalid configurations force low
    pwmStart(50, 25, 1'b0);
    pwmMeasure(50, 25, "pre");
    wr(0, PSET | CS);
    idle(1);
    stayLow(120, "R12 cascade on timer 0");
    pwmStart(50, 25, 1'b0);
    pwmMeasure(50, 25, "pre");
    wr(3, PSET | LD);
    idle(1);
    stayLow(120, "R12 load bit on timer 1");
    pwmStart(50, 25, 1'b1);
    pwmMeasure(50, 25, "pre");
    wr(3, 0);
    idle(1);
    stayLow(120, "R12 timer 1 disabled");

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule